// File: doc/BRIEF.md
# Descriptor-Chained Storage DMA Engine

This block is a single-channel bus-master DMA engine placed between a storage device's word stream and system memory. Software builds a table of region descriptors in memory, where each entry is two 32-bit words: a buffer address, then a control word holding a byte count and an end marker. Software writes the table's location and then sets the run bit, with a direction bit in the same command write. The engine walks the table one entry at a time. It fetches each entry with two memory reads, then moves that region one 32-bit word per memory handshake. It stops after the region whose entry carries the end marker.

Completion is read from two status bits. A device interrupt latches one of them. The other shows the engine still running. Together they tell software whether the buffers matched the transfer exactly, whether buffer space was left over, or whether the descriptors ran out before the device finished. Software acknowledges by writing the read status value back. It halts the engine by rewriting the command value with the run and direction bits cleared.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset the command, status and table address registers (register select 0, 1 and 2) all read as zero, and the engine is idle.
- R2: The command register stores all eight written bits and reads them back. Rewriting the read value masked with 0xF6 leaves bits 7:4 and 2:1 unchanged.
- R3: Writing command bit 0 as 1 while it reads 0 starts the engine. The first memory request is a read of the table address with its two low bits forced to zero. Each entry is two reads: the first word is the buffer address, and in the second word bits 15:0 are the byte count and bit 31 marks the last entry.
- R4: Command bit 3, sampled at start, selects direction. A 1 moves device input words into memory. A 0 reads memory words and presents them on the device output.
- R5: Each region moves count/4 words at consecutive word addresses from its buffer address. A byte count of zero means 65536 bytes (16384 words).
- R6: Exact fit: once the last-marked region is fully moved, status bit 0 (active) clears. A device interrupt latches status bit 2, giving status 0x4.
- R7: Larger buffer: when the device stops supplying data and raises its interrupt before the descriptors are used up, the engine stays active and status reads 0x5.
- R8: Short buffer: when the descriptors run out before the device is done, active clears with bit 2 still clear. Exactly the described number of words is taken from the device.
- R9: Status bits 1 and 2 clear when written with 1 and are kept when written with 0. Bit 0 ignores writes. An incoming interrupt or error in the same cycle as the clearing write wins.
- R10: Writing command bit 0 as 0 makes the engine inactive on the next cycle and withdraws every memory and device request.
- R11: The error input latches status bit 1. A running engine then freezes with active still set and moves no more data until it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, completes the beat |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_in_valid | input | 1 | Device word available |
| dev_in_ready | output | 1 | Engine accepts a device word |
| dev_in_data | input | 32 | Device word |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_out_data | output | 32 | Word to the device |
| dev_irq | input | 1 | Device interrupt pulse |
| dev_err | input | 1 | Device or bus error pulse |

## Verification
The assertions check the cycle-level rules on every cycle. A pending memory request holds its address until acknowledged. A stop write or an error silences all requests on the next cycle. An idle engine drives no request, and the two stream directions never run at once. An interrupt always leaves the latched bit set. A new run opens with a word-aligned table read. Only the bench scenarios can show the data-level results: which words land at which addresses, the three completion outcomes, the 65536-byte reading of a zero count, and the status and command values after acknowledge and stop.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int CNT_W = 17;
    localparam int BEAT  = DW / 8;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_TBL  = 2'd2;

    localparam int CMD_RUN   = 0;
    localparam int CMD_TOMEM = 3;
    localparam int ST_ACT    = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_IRQ    = 2;
    localparam int LAST_BIT  = 31;

    typedef enum logic [2:0] {
        W_IDLE, W_DESC0, W_DESC1, W_MEMRD, W_DEVOUT, W_DEVIN, W_MEMWR, W_HALT
    } walk_e;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] bytes;
        logic             last;
    } region_t;

    function automatic logic [CNT_W-1:0] region_bytes(input logic [15:0] raw);
        return (raw == 16'd0) ? {1'b1, 16'd0} : {1'b0, raw};
    endfunction
endpackage

// File: rtl/prd_dma_regs.sv
module prd_dma_regs
    import prd_dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          active_i,
    input  logic          dev_irq,
    input  logic          dev_err,
    output logic          start_o,
    output logic          stop_o,
    output logic          tomem_o,
    output logic [AW-3:0] tbl_o,
    output logic          irq_o
);
    logic [7:0]    cmd_q;
    logic [AW-3:0] tbl_q;
    logic          err_q, irq_q;
    logic          wr_cmd, wr_stat, wr_tbl;

    assign wr_cmd  = reg_wr && (reg_addr == SEL_CMD);
    assign wr_stat = reg_wr && (reg_addr == SEL_STAT);
    assign wr_tbl  = reg_wr && (reg_addr == SEL_TBL);

    assign start_o = wr_cmd && reg_wdata[CMD_RUN] && !cmd_q[CMD_RUN];
    assign stop_o  = wr_cmd && !reg_wdata[CMD_RUN];
    assign tomem_o = reg_wdata[CMD_TOMEM];
    assign tbl_o   = tbl_q;
    assign irq_o   = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            tbl_q <= '0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= reg_wdata[7:0];
            if (wr_tbl) tbl_q <= reg_wdata[AW-1:2];
            if (dev_err)                            err_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_ERR])  err_q <= 1'b0;
            if (dev_irq)                            irq_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_IRQ])  irq_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_CMD:  reg_rdata = {{(DW-8){1'b0}}, cmd_q};
            SEL_STAT: reg_rdata = {{(DW-3){1'b0}}, irq_q, err_q, active_i};
            SEL_TBL:  reg_rdata = {tbl_q, 2'b00};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/prd_dma_walker.sv
module prd_dma_walker
    import prd_dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          tomem_i,
    input  logic [AW-3:0] tbl_i,
    input  logic          dev_err,
    output logic          active_o,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data
);
    walk_e         st;
    region_t       cur;
    logic [AW-1:0] tptr;
    logic [DW-1:0] hold;
    logic          tomem_q;
    logic          beat_done, region_end;
    walk_e         after_beat, move_state;
    logic          unused_ctl;

    assign unused_ctl = &{1'b0, mem_rdata[LAST_BIT-1:16]};

    assign move_state = tomem_q ? W_DEVIN : W_MEMRD;
    assign region_end = (cur.bytes <= CNT_W'(BEAT));
    assign after_beat = region_end ? (cur.last ? W_IDLE : W_DESC0) : move_state;
    assign beat_done  = ((st == W_MEMWR) && mem_ack) || ((st == W_DEVOUT) && dev_out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= W_IDLE;
            cur     <= '0;
            tptr    <= '0;
            hold    <= '0;
            tomem_q <= 1'b0;
        end else if (stop_i) begin
            st <= W_IDLE;
        end else if (dev_err && (st != W_IDLE || start_i)) begin
            st <= W_HALT;
        end else begin
            case (st)
                W_IDLE: if (start_i) begin
                    tptr    <= {tbl_i, 2'b00};
                    tomem_q <= tomem_i;
                    st      <= W_DESC0;
                end
                W_DESC0: if (mem_ack) begin
                    cur.addr <= mem_rdata;
                    st       <= W_DESC1;
                end
                W_DESC1: if (mem_ack) begin
                    cur.bytes <= region_bytes(mem_rdata[15:0]);
                    cur.last  <= mem_rdata[LAST_BIT];
                    tptr      <= tptr + AW'(2 * BEAT);
                    st        <= move_state;
                end
                W_MEMRD: if (mem_ack) begin
                    hold <= mem_rdata;
                    st   <= W_DEVOUT;
                end
                W_DEVIN: if (dev_in_valid) begin
                    hold <= dev_in_data;
                    st   <= W_MEMWR;
                end
                W_MEMWR, W_DEVOUT: if (beat_done) begin
                    cur.addr  <= cur.addr + AW'(BEAT);
                    cur.bytes <= cur.bytes - CNT_W'(BEAT);
                    st        <= after_beat;
                end
                default: st <= st;
            endcase
        end
    end

    assign active_o      = (st != W_IDLE);
    assign mem_req       = (st == W_DESC0) || (st == W_DESC1) || (st == W_MEMRD) || (st == W_MEMWR);
    assign mem_we        = (st == W_MEMWR);
    assign mem_wdata     = hold;
    assign dev_in_ready  = (st == W_DEVIN);
    assign dev_out_valid = (st == W_DEVOUT);
    assign dev_out_data  = hold;

    always_comb begin
        case (st)
            W_DESC0: mem_addr = tptr;
            W_DESC1: mem_addr = tptr + AW'(BEAT);
            default: mem_addr = cur.addr;
        endcase
    end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [31:0]   dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [31:0]   dev_out_data,
    input  logic          dev_irq,
    input  logic          dev_err
);
    logic          eng_active, irq_flag;
    logic          start_w, stop_w, tomem_w;
    logic [AW-3:0] tbl_w;

    prd_dma_regs regs_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .active_i(eng_active), .dev_irq(dev_irq), .dev_err(dev_err),
        .start_o(start_w), .stop_o(stop_w), .tomem_o(tomem_w), .tbl_o(tbl_w), .irq_o(irq_flag)
    );

    prd_dma_walker walk_i (
        .clk(clk), .rst(rst),
        .start_i(start_w), .stop_i(stop_w), .tomem_i(tomem_w), .tbl_i(tbl_w),
        .dev_err(dev_err), .active_o(eng_active),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data)
    );
endmodule

// File: rtl/prd_dma_engine_chk.sv
module prd_dma_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        dev_in_ready,
    input logic        dev_out_valid,
    input logic        dev_irq,
    input logic        dev_err,
    input logic        active,
    input logic        irq_flag
);
    logic stop_wr;
    assign stop_wr = reg_wr && (reg_addr == 2'd0) && !reg_wdata[0];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !dev_err && !stop_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !active && !mem_req && !dev_in_ready && !dev_out_valid); // R10
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mem_req && !dev_in_ready && !dev_out_valid); // R1
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(dev_in_ready && dev_out_valid)); // R4
    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst)
        dev_err |=> !mem_req && !dev_in_ready && !dev_out_valid); // R11
    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (rst)
        dev_irq |=> irq_flag); // R9
    AST_START_FETCH: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> mem_req && !mem_we && (mem_addr[1:0] == 2'b00)); // R3
endmodule

bind prd_dma_engine prd_dma_engine_chk chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_irq(dev_irq), .dev_err(dev_err), .active(eng_active), .irq_flag(irq_flag)
);

// File: tb/prd_dma_engine_tb_top.sv
module prd_dma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
    logic [31:0] dev_in_data, dev_out_data;
    logic        dev_irq = 1'b0, dev_err = 1'b0;

    logic [31:0] tmem [0:4095];
    logic [31:0] src  [0:4095];
    int src_i = 0, src_n = 0, sink_n = 0, out_bad = 0, wr_n = 0, in_bad = 0;
    int sink_start = 0, out_base_w = 0, in_base_w = 0, src_start = 0;
    int ntot = 0, nbad = 0;

    always #2 clk = ~clk;

    prd_dma_engine dut_i (.*);

    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; dev_in_valid = 1'b0; dev_out_ready = 1'b0;
            mem_rdata = '0; dev_in_data = '0;
        end else begin
            mem_ack   = mem_req && ($urandom % 4 != 0);
            mem_rdata = tmem[mem_addr[13:2]];
            if (mem_ack && mem_we) begin
                if (mem_wdata !== src[(src_start + int'(mem_addr[13:2]) - in_base_w) % 4096]) in_bad++;
                wr_n++;
            end
            dev_in_valid = (src_n > src_i) && ($urandom % 4 != 0);
            dev_in_data  = src[src_i % 4096];
            if (dev_in_valid && dev_in_ready) src_i++;
            dev_out_ready = ($urandom % 4 != 0);
            if (dev_out_ready && dev_out_valid) begin
                if (dev_out_data !== tmem[(out_base_w + sink_n - sink_start) % 4096]) out_bad++;
                sink_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse_irq();
        @(negedge clk); dev_irq = 1'b1; @(negedge clk); dev_irq = 1'b0;
    endtask

    task automatic put_desc(input int idx, input logic [31:0] a, input logic [15:0] c, input bit last);
        tmem[2*idx]     = a;
        tmem[2*idx + 1] = {last, 15'd0, c};
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic stop_and_ack(input string req);
        logic [31:0] c, s;
        reg_read(2'd0, c);
        reg_write(2'd0, c & 32'hF6);
        reg_read(2'd0, s);
        chk({req, " R2 stop keeps other command bits"}, s, c & 32'hF6);
        reg_read(2'd1, s);
        chk({req, " R10 inactive after stop"}, {31'd0, s[0]}, 32'd0);
        reg_write(2'd1, s);
        reg_read(2'd1, s);
        chk({req, " R9 write-back acknowledge clears status"}, s, 32'd0);
    endtask

    task automatic run_in(input int nd, input int wpd, input int devw, input logic [1:0] lowb);
        logic [31:0] s;
        int total, w0, quiet;
        total = nd * wpd;
        for (int i = 0; i < nd; i++)
            put_desc(i, 32'h2000 + i * wpd * 4, 16'(wpd * 4), i == nd - 1);
        in_base_w = 32'h800;
        src_start = src_i;
        for (int k = 0; k < devw; k++) src[(src_start + k) % 4096] = $urandom;
        w0 = wr_n; in_bad = 0;
        src_n = src_start + devw;
        reg_write(2'd2, {30'd0, lowb});
        reg_write(2'd0, 32'h49);
        quiet = 0;
        for (int g = 0; g < 60000; g++) begin
            reg_read(2'd1, s);
            if (!s[0]) break;
            if (src_i == src_n) quiet++;
            if (quiet > 40) break;
        end
        if (devw <= total) pulse_irq();
        repeat (3) @(negedge clk);
        reg_read(2'd1, s);
        if (devw == total)     chk("R6 exact-fit status", s, 32'h4);
        else if (devw < total) chk("R7 larger-buffer status", s, 32'h5);
        else                   chk("R8 short-buffer status", s, 32'h0);
        if (devw > total) chk("R8 words taken from device", 32'(src_i - src_start), 32'(total));
        chk("R4 words written to memory", 32'(wr_n - w0), 32'(min2(devw, total)));
        chk("R5 memory contents and addresses", 32'(in_bad), 32'd0);
        src_n = src_i;
        stop_and_ack("in");
    endtask

    task automatic run_out(input int nd, input int wpd, input bit zero);
        logic [31:0] s;
        int total;
        total = zero ? 16384 : nd * wpd;
        for (int k = 0; k < 4096; k++) tmem[k] = $urandom;
        if (zero) put_desc(0, 32'h4000, 16'd0, 1'b1);
        else for (int i = 0; i < nd; i++)
            put_desc(i, 32'h4000 + i * wpd * 4, 16'(wpd * 4), i == nd - 1);
        out_base_w = 32'h1000;
        sink_start = sink_n; out_bad = 0;
        reg_write(2'd2, 32'd0);
        reg_write(2'd0, 32'h01);
        for (int g = 0; g < 120000; g++) begin
            reg_read(2'd1, s);
            if (!s[0]) break;
        end
        chk(zero ? "R5 zero count gives 16384 words" : "R4 words sent to device", 32'(sink_n - sink_start), 32'(total));
        chk("R4 device output data", 32'(out_bad), 32'd0);
        chk("R6 idle after last region", s, 32'h0);
        stop_and_ack("out");
    endtask

    task automatic tests();
        logic [31:0] v;
        int snap;
        void'($urandom(32'h5eed));
        for (int k = 0; k < 4096; k++) begin tmem[k] = '0; src[k] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 3; a++) begin
            reg_read(2'(a), v);
            chk("R1 reset value", v, 32'd0);
        end
        reg_write(2'd0, 32'hB6);
        reg_read(2'd0, v);
        chk("R2 command readback", v, 32'hB6);
        reg_write(2'd0, 32'h0);
        reg_write(2'd2, 32'h1234_5677);
        reg_read(2'd2, v);
        chk("R3 table low bits ignored", v, 32'h1234_5674);
        pulse_irq();
        reg_read(2'd1, v);
        chk("R9 interrupt latched while idle", v, 32'h4);
        reg_write(2'd1, 32'h1);
        reg_read(2'd1, v);
        chk("R9 zero and active-bit write keep status", v, 32'h4);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h4; dev_irq = 1'b1;
        @(negedge clk); reg_wr = 1'b0; dev_irq = 1'b0;
        reg_read(2'd1, v);
        chk("R9 new interrupt beats clear", v, 32'h4);
        reg_write(2'd1, 32'h4);
        reg_read(2'd1, v);
        chk("R9 clear on one", v, 32'h0);

        run_in(2, 16, 32, 2'd3);
        run_in(3, 10, 17, 2'd0);
        run_in(1, 12, 40, 2'd1);
        run_out(2, 20, 1'b0);
        for (int r = 0; r < 4; r++) begin
            int nd, wpd, mode;
            nd = 1 + $urandom % 3; wpd = 1 + $urandom % 40; mode = $urandom % 4;
            if (mode == 3) run_out(nd, wpd, 1'b0);
            else run_in(nd, wpd, nd * wpd + mode - 1, 2'(r));
        end

        for (int i = 0; i < 1; i++) put_desc(i, 32'h2000, 16'd4000, 1'b1);
        src_start = src_i;
        for (int k = 0; k < 1000; k++) src[(src_start + k) % 4096] = $urandom;
        src_n = src_start + 1000;
        reg_write(2'd2, 32'd0);
        reg_write(2'd0, 32'h09);
        for (int g = 0; g < 5000 && src_i < src_start + 20; g++) @(negedge clk);
        @(negedge clk); dev_err = 1'b1; @(negedge clk); dev_err = 1'b0;
        repeat (2) @(negedge clk);
        snap = src_i;
        repeat (30) @(negedge clk);
        chk("R11 no data after error", 32'(src_i), 32'(snap));
        reg_read(2'd1, v);
        chk("R11 error latched engine held", v, 32'h3);
        reg_write(2'd1, 32'h2);
        reg_read(2'd1, v);
        chk("R9 error cleared by writing one", v, 32'h1);
        src_n = src_i;
        stop_and_ack("err");

        run_out(1, 0, 1'b1);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            tests();
            begin repeat (190000) @(posedge clk); timed_out = 1'b1; end
        join_any
        disable fork;
        if (timed_out) begin
            ntot++; nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule